// File: doc/BRIEF.md
# Temperature Threshold Monitor

This block watches the results of a temperature converter. Each time the converter signals a finished conversion, the 16-bit result is stored and compared against four limits: high, low, critical high and critical low. A result above the high or critical-high limit, or below the low or critical-low limit, sets a status flag. Each flag stays set until software clears it by writing 1 to its bit. Two further flags record bus errors: a packet-checksum error and a parity error. Each interrupt source has an enable bit. When any enabled source has its flag set, the block reports a pending interrupt.

The block also decides when the converter may start new conversions. A small sequencer has three states. In RUN the converter is enabled. In DRAIN a disable request has arrived while a conversion is in flight, and the block waits for that result. In HALT the converter is stopped. The transitions are:

- run_to_drain: disable is requested while the converter is busy and not finishing.
- run_to_halt: disable is requested while the converter is idle, or finishing in that same cycle.
- drain_to_halt: the outstanding result arrives and disable is still set.
- drain_to_run: the outstanding result arrives after disable has already been withdrawn.
- halt_to_run: disable is withdrawn.

Top module: `thermal_watch`

## Requirements
- R1: After reset, temp_status_o, err_status_o and dev_status_o read 00h, temp_value_o reads 0000h and conv_en_o is 1.
- R2: A result accepted on conv_done_i sets bit 0 of temp_status_o when the result is greater than lim_high_i. It sets bit 2 when the result is greater than lim_crit_high_i. A result equal to a limit sets nothing. All comparisons are unsigned.
- R3: An accepted result sets bit 1 of temp_status_o when it is less than lim_low_i. It sets bit 3 when it is less than lim_crit_low_i. Bits 7:4 of temp_status_o always read 0.
- R4: A temperature or error flag, once set, stays set while later results fall inside the limits, until a clear is written.
- R5: When temp_clr_we_i is high, each 1 in temp_clr_i[3:0] clears the flag with the same bit number in temp_status_o. Bits written as 0 leave their flags unchanged.
- R6: If a flag's set condition and its clear arrive in the same cycle, the flag ends up set.
- R7: par_err_i sets bit 0 of err_status_o and chk_err_i sets bit 1. When err_clr_we_i is high, each 1 in err_clr_i[1:0] clears the matching bit. A simultaneous error event wins over its clear. Bits 7:2 read 0.
- R8: A write on cfg_we_i stores cfg_data_i[3:0] as the enables for temperature flags 0 to 3, and cfg_data_i[4] as the enable for any error flag. Bit 7 of dev_status_o is 1 exactly when some enabled source has its flag set. Bits 6:0 of dev_status_o read 0.
- R9: A cfg_we_i write with cfg_data_i[7] = 1 clears all temperature and error flags in one cycle. This drops the pending bit. The enables are still loaded from the same write.
- R10: When sensor_dis_i is set while conv_busy_i is low, conv_en_o goes low after one clock edge.
- R11: When sensor_dis_i is set while conv_busy_i is high, conv_en_o goes low after one clock edge. The next conv_done_i is still accepted, updating temp_value_o and the flags, and conv_en_o then stays low.
- R12: While halted, conv_done_i is ignored. temp_value_o and temp_status_o keep their values.
- R13: Clearing sensor_dis_i in the halted state raises conv_en_o after one clock edge.
- R14: temp_value_o holds the most recently accepted result. It is updated one clock edge after the accepting conv_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle strobe: conversion finished |
| conv_result_i | input | 16 | Conversion result, valid with conv_done_i |
| conv_busy_i | input | 1 | Converter has a conversion in flight |
| lim_high_i | input | 16 | High limit |
| lim_low_i | input | 16 | Low limit |
| lim_crit_high_i | input | 16 | Critical high limit |
| lim_crit_low_i | input | 16 | Critical low limit |
| temp_clr_we_i | input | 1 | Write strobe for the temperature-flag clear bits |
| temp_clr_i | input | 4 | Clear bits: a 1 clears the temperature flag with the same bit number |
| err_clr_we_i | input | 1 | Write strobe for the error-flag clear bits |
| err_clr_i | input | 2 | Clear bits: a 1 clears the error flag with the same bit number |
| cfg_we_i | input | 1 | Write strobe for the interrupt configuration |
| cfg_data_i | input | 8 | Configuration data: bits 4:0 are enables, bit 7 is the global clear |
| sensor_dis_i | input | 1 | Request to stop conversions |
| par_err_i | input | 1 | Parity error event |
| chk_err_i | input | 1 | Packet-checksum error event |
| temp_status_o | output | 8 | Temperature flags: bit 0 high, bit 1 low, bit 2 critical high, bit 3 critical low |
| err_status_o | output | 8 | Error flags: bit 0 parity, bit 1 checksum |
| dev_status_o | output | 8 | Bit 7 is the pending-interrupt flag |
| conv_en_o | output | 1 | Converter may start conversions |
| temp_value_o | output | 16 | Last accepted result |

## Verification
Two cases can fall in the same cycle. First, a conversion result that crosses a limit can arrive together with a clear write for that flag. Second, a disable request can arrive in the same cycle as conv_done_i, or while the converter is busy.

The bench provokes the first case by driving conv_done_i and temp_clr_we_i together, and by driving chk_err_i together with its error clear. The flag must end up set. It provokes the second case by raising sensor_dis_i during a busy conversion and again in an idle cycle, then checking whether the result is absorbed or ignored.

A behavioural model, updated on every clock edge, judges each of these outcomes. The model's values are compared with all outputs on every cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int TW_DW      = 16;
    localparam int TW_NLIM    = 4;
    localparam int TW_NERR    = 2;
    localparam int TW_REGW    = 8;

    // temperature flag positions
    localparam int FL_HIGH    = 0;
    localparam int FL_LOW     = 1;
    localparam int FL_CHIGH   = 2;
    localparam int FL_CLOW    = 3;

    // error flag positions
    localparam int ER_PAR     = 0;
    localparam int ER_CHK     = 1;

    // configuration bits
    localparam int CFG_ERR_EN = 4;
    localparam int CFG_GCLR   = 7;
    localparam int DEV_PEND   = 7;

    // flags that fire above their limit (others fire below)
    localparam logic [TW_NLIM-1:0] ABOVE_MASK = 4'b0101;

    typedef enum logic [1:0] {
        SEQ_RUN   = 2'd0,
        SEQ_DRAIN = 2'd1,
        SEQ_HALT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tw_cmp.sv
module tw_cmp #(
    parameter int DW = 16,
    parameter int N  = 4,
    parameter logic [N-1:0] ABOVE = '0
) (
    input  logic              valid_i,
    input  logic [DW-1:0]     value_i,
    input  logic [N-1:0][DW-1:0] lim_i,
    output logic [N-1:0]      hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        if (ABOVE[g]) begin : g_above
            assign hit_o[g] = valid_i && (value_i > lim_i[g]);
        end else begin : g_below
            assign hit_o[g] = valid_i && (value_i < lim_i[g]);
        end
    end
endmodule

// File: rtl/tw_sticky.sv
module tw_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         gclr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] q_q;
    logic [N-1:0] keep;

    always_comb begin
        keep = q_q & ~clr_i;
        if (gclr_i) begin
            keep = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= keep | set_i;
        end
    end

    assign q_o = q_q;

    // R4: without set or clear, flags keep their value
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0 && !gclr_i) |=> $stable(q_o));

    // R5: a requested clear takes effect where no set competes
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

    // R6: a set in the same cycle as a clear wins
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R9: global clear empties every flag not being set
    a_r9_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
        gclr_i |=> ((q_o & ~$past(set_i)) == '0));
endmodule

// File: rtl/tw_seq.sv
module tw_seq
    import tw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dis_i,
    input  logic busy_i,
    input  logic done_i,
    output logic conv_en_o,
    output logic accept_o
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_RUN: begin
                if (dis_i) begin
                    // run_to_drain / run_to_halt
                    state_d = (busy_i && !done_i) ? SEQ_DRAIN : SEQ_HALT;
                end
            end
            SEQ_DRAIN: begin
                if (done_i) begin
                    // drain_to_halt / drain_to_run
                    state_d = dis_i ? SEQ_HALT : SEQ_RUN;
                end
            end
            SEQ_HALT: begin
                if (!dis_i) begin
                    state_d = SEQ_RUN; // halt_to_run
                end
            end
            default: state_d = SEQ_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        conv_en_o = 1'b0;
        accept_o  = 1'b0;
        unique case (state_q)
            SEQ_RUN:   begin conv_en_o = 1'b1; accept_o = done_i; end
            SEQ_DRAIN: begin conv_en_o = 1'b0; accept_o = done_i; end
            SEQ_HALT:  begin conv_en_o = 1'b0; accept_o = 1'b0;   end
            default:   begin conv_en_o = 1'b0; accept_o = 1'b0;   end
        endcase
    end

    // R10: idle disable stops conversions after one edge
    a_r10_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_en_o && dis_i && !busy_i) |=> !conv_en_o);

    // R11: draining keeps the converter disabled until the result arrives
    a_r11_drain_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_DRAIN && !done_i) |=> (state_q == SEQ_DRAIN && !conv_en_o));

    // R13: withdrawing disable while halted restarts conversions
    a_r13_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HALT && !dis_i) |=> conv_en_o);
endmodule

// File: rtl/thermal_watch.sv
module thermal_watch
    import tw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        conv_done_i,
    input  logic [15:0] conv_result_i,
    input  logic        conv_busy_i,
    input  logic [15:0] lim_high_i,
    input  logic [15:0] lim_low_i,
    input  logic [15:0] lim_crit_high_i,
    input  logic [15:0] lim_crit_low_i,
    input  logic        temp_clr_we_i,
    input  logic [3:0]  temp_clr_i,
    input  logic        err_clr_we_i,
    input  logic [1:0]  err_clr_i,
    input  logic        cfg_we_i,
    input  logic [7:0]  cfg_data_i,
    input  logic        sensor_dis_i,
    input  logic        par_err_i,
    input  logic        chk_err_i,
    output logic [7:0]  temp_status_o,
    output logic [7:0]  err_status_o,
    output logic [7:0]  dev_status_o,
    output logic        conv_en_o,
    output logic [15:0] temp_value_o
);
    localparam int NEN = TW_NLIM + 1;

    logic                     accept;
    logic [TW_NLIM-1:0]       hit;
    logic [TW_NLIM-1:0][TW_DW-1:0] lims;
    logic [TW_NLIM-1:0]       temp_clr;
    logic [TW_NLIM-1:0]       temp_q;
    logic [TW_NERR-1:0]       err_set;
    logic [TW_NERR-1:0]       err_clr;
    logic [TW_NERR-1:0]       err_q;
    logic                     gclr;
    logic [NEN-1:0]           irq_en_q;
    logic [TW_DW-1:0]         value_q;
    logic                     pending;
    logic                     unused_cfg;

    assign unused_cfg = ^cfg_data_i[6:5];

    assign lims[FL_HIGH]  = lim_high_i;
    assign lims[FL_LOW]   = lim_low_i;
    assign lims[FL_CHIGH] = lim_crit_high_i;
    assign lims[FL_CLOW]  = lim_crit_low_i;

    assign gclr     = cfg_we_i && cfg_data_i[CFG_GCLR];
    assign temp_clr = temp_clr_we_i ? temp_clr_i : '0;
    assign err_clr  = err_clr_we_i ? err_clr_i : '0;

    always_comb begin
        err_set         = '0;
        err_set[ER_PAR] = par_err_i;
        err_set[ER_CHK] = chk_err_i;
    end

    tw_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dis_i     (sensor_dis_i),
        .busy_i    (conv_busy_i),
        .done_i    (conv_done_i),
        .conv_en_o (conv_en_o),
        .accept_o  (accept)
    );

    tw_cmp #(
        .DW    (TW_DW),
        .N     (TW_NLIM),
        .ABOVE (ABOVE_MASK)
    ) u_cmp (
        .valid_i (accept),
        .value_i (conv_result_i),
        .lim_i   (lims),
        .hit_o   (hit)
    );

    tw_sticky #(.N(TW_NLIM)) u_temp_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .clr_i  (temp_clr),
        .gclr_i (gclr),
        .q_o    (temp_q)
    );

    tw_sticky #(.N(TW_NERR)) u_err_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .clr_i  (err_clr),
        .gclr_i (gclr),
        .q_o    (err_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= '0;
        end else if (cfg_we_i) begin
            irq_en_q <= cfg_data_i[NEN-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (accept) begin
            value_q <= conv_result_i;
        end
    end

    assign pending = (|(temp_q & irq_en_q[TW_NLIM-1:0]))
                   || ((|err_q) && irq_en_q[CFG_ERR_EN]);

    always_comb begin
        temp_status_o                = '0;
        temp_status_o[TW_NLIM-1:0]   = temp_q;
        err_status_o                 = '0;
        err_status_o[TW_NERR-1:0]    = err_q;
        dev_status_o                 = '0;
        dev_status_o[DEV_PEND]       = pending;
    end

    assign temp_value_o = value_q;

    // R8: no flags set means nothing pending
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_status_o == 8'h00 && err_status_o == 8'h00) |-> !dev_status_o[DEV_PEND]);

    // R9: global clear with no competing event empties both status bytes
    a_r9_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (gclr && !accept && !par_err_i && !chk_err_i)
        |=> (temp_status_o == 8'h00 && err_status_o == 8'h00 && !dev_status_o[DEV_PEND]));

    // R14: stored result only moves on an accepted conversion
    a_r14_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(temp_value_o));

    // R12: while conversions are off and no drain pending, results are dropped
    a_r12_halt_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_en_o && !conv_busy_i && !accept && !gclr && !temp_clr_we_i)
        |=> $stable(temp_status_o));
endmodule

// File: tb/thermal_watch_tb_top.sv
`timescale 1ns/1ps
module thermal_watch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_result = '0;
    logic        conv_busy = 1'b0;
    logic [15:0] lim_hi = 16'h0370;
    logic [15:0] lim_lo = 16'h0100;
    logic [15:0] lim_ch = 16'h0550;
    logic [15:0] lim_cl = 16'h0080;
    logic        tclr_we = 1'b0;
    logic [3:0]  tclr = '0;
    logic        eclr_we = 1'b0;
    logic [1:0]  eclr = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic        dis = 1'b0;
    logic        par_err = 1'b0;
    logic        chk_err = 1'b0;
    logic [7:0]  temp_status, err_status, dev_status;
    logic        conv_en;
    logic [15:0] temp_value;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    thermal_watch dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .conv_done_i     (conv_done),
        .conv_result_i   (conv_result),
        .conv_busy_i     (conv_busy),
        .lim_high_i      (lim_hi),
        .lim_low_i       (lim_lo),
        .lim_crit_high_i (lim_ch),
        .lim_crit_low_i  (lim_cl),
        .temp_clr_we_i   (tclr_we),
        .temp_clr_i      (tclr),
        .err_clr_we_i    (eclr_we),
        .err_clr_i       (eclr),
        .cfg_we_i        (cfg_we),
        .cfg_data_i      (cfg_data),
        .sensor_dis_i    (dis),
        .par_err_i       (par_err),
        .chk_err_i       (chk_err),
        .temp_status_o   (temp_status),
        .err_status_o    (err_status),
        .dev_status_o    (dev_status),
        .conv_en_o       (conv_en),
        .temp_value_o    (temp_value)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [3:0]  m_t = '0;
    logic [1:0]  m_e = '0;
    logic [4:0]  m_en = '0;
    logic [15:0] m_val = '0;
    int          m_st = 0; // 0 running, 1 waiting for result, 2 stopped

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = '0; m_e = '0; m_en = '0; m_val = '0; m_st = 0;
        end else begin
            bit acc;
            logic [3:0] hits;
            acc  = conv_done && (m_st != 2);
            hits = '0;
            if (acc) begin
                if (conv_result > lim_hi) hits[0] = 1'b1;
                if (conv_result < lim_lo) hits[1] = 1'b1;
                if (conv_result > lim_ch) hits[2] = 1'b1;
                if (conv_result < lim_cl) hits[3] = 1'b1;
                m_val = conv_result;
            end
            if (tclr_we) m_t = m_t & ~tclr;
            if (eclr_we) m_e = m_e & ~eclr;
            if (cfg_we && cfg_data[7]) begin m_t = '0; m_e = '0; end
            m_t = m_t | hits;
            if (par_err) m_e[0] = 1'b1;
            if (chk_err) m_e[1] = 1'b1;
            if (cfg_we) m_en = cfg_data[4:0];
            case (m_st)
                0: if (dis) m_st = (conv_busy && !conv_done) ? 1 : 2;
                1: if (conv_done) m_st = dis ? 2 : 0;
                default: if (!dis) m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit pend;
            pend = ((m_t & m_en[3:0]) != 0) || ((m_e != 0) && m_en[4]);
            chk("R4 model temp_status", temp_status, {4'h0, m_t});
            chk("R7 model err_status", err_status, {6'h0, m_e});
            chk("R8 model dev_status", dev_status, {pend, 7'h0});
            chk("R10 model conv_en", conv_en, (m_st == 0));
            chk("R14 model temp_value", temp_value, m_val);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // busy for two cycles, then a finishing strobe with optional clear
    task automatic convert(input logic [15:0] v, input logic [3:0] clr_bits);
        conv_busy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        conv_busy = 1'b0;
        conv_done = 1'b1;
        conv_result = v;
        if (clr_bits != 0) begin tclr_we = 1'b1; tclr = clr_bits; end
        @(negedge clk);
        conv_done = 1'b0;
        tclr_we = 1'b0;
        tclr = '0;
    endtask

    task automatic wr_tclr(input logic [3:0] b);
        tclr_we = 1'b1; tclr = b;
        @(negedge clk);
        tclr_we = 1'b0; tclr = '0;
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        cfg_we = 1'b1; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 temp_status", temp_status, 8'h00);
        chk("R1 err_status", err_status, 8'h00);
        chk("R1 dev_status", dev_status, 8'h00);
        chk("R1 conv_en", conv_en, 1'b1);
        chk("R1 temp_value", temp_value, 16'h0000);

        convert(16'h0370, 4'h0);
        chk("R2 equal to high limit", temp_status, 8'h00);
        chk("R14 value stored", temp_value, 16'h0370);
        convert(16'h0371, 4'h0);
        chk("R2 above high", temp_status, 8'h01);
        convert(16'h0551, 4'h0);
        chk("R2 above critical high", temp_status, 8'h05);
        convert(16'h0200, 4'h0);
        chk("R4 flags stay set", temp_status, 8'h05);

        wr_tclr(4'h4);
        chk("R5 clear bit 2", temp_status, 8'h01);
        wr_tclr(4'h0);
        chk("R5 zero write no effect", temp_status, 8'h01);

        convert(16'h0100, 4'h0);
        chk("R3 equal to low limit", temp_status, 8'h01);
        convert(16'h00FF, 4'h0);
        chk("R3 below low", temp_status, 8'h03);
        convert(16'h007F, 4'h0);
        chk("R3 below critical low", temp_status, 8'h0B);

        convert(16'hFFFF, 4'h1);
        chk("R6 set beats clear", temp_status, 8'h0F);

        par_err = 1'b1; @(negedge clk); par_err = 1'b0;
        chk("R7 parity error", err_status, 8'h01);
        chk_err = 1'b1; @(negedge clk); chk_err = 1'b0;
        chk("R7 checksum error", err_status, 8'h03);
        eclr_we = 1'b1; eclr = 2'b01; @(negedge clk);
        chk("R7 clear parity", err_status, 8'h02);
        chk_err = 1'b1; eclr = 2'b10; @(negedge clk);
        chk_err = 1'b0; eclr_we = 1'b0; eclr = '0;
        chk("R7 event beats clear", err_status, 8'h02);

        chk("R8 no enables", dev_status, 8'h00);
        wr_tclr(4'hD);
        wr_cfg(8'h01);
        chk("R8 masked source idle", dev_status, 8'h00);
        wr_cfg(8'h02);
        chk("R8 low enable", dev_status, 8'h80);
        wr_cfg(8'h10);
        chk("R8 error enable", dev_status, 8'h80);
        eclr_we = 1'b1; eclr = 2'b11; @(negedge clk); eclr_we = 1'b0; eclr = '0;
        chk("R8 pending drops", dev_status, 8'h00);

        par_err = 1'b1; @(negedge clk); par_err = 1'b0;
        wr_cfg(8'h81);
        chk("R9 temp cleared", temp_status, 8'h00);
        chk("R9 err cleared", err_status, 8'h00);
        chk("R9 pending cleared", dev_status, 8'h00);
        convert(16'h0400, 4'h0);
        chk("R9 enables loaded", dev_status, 8'h80);

        dis = 1'b1; @(negedge clk);
        chk("R10 idle stop", conv_en, 1'b0);
        conv_done = 1'b1; conv_result = 16'h0600; @(negedge clk);
        conv_done = 1'b0;
        chk("R12 value kept", temp_value, 16'h0400);
        chk("R12 status kept", temp_status, 8'h01);
        dis = 1'b0; @(negedge clk);
        chk("R13 restart", conv_en, 1'b1);

        conv_busy = 1'b1; @(negedge clk);
        dis = 1'b1; @(negedge clk);
        chk("R11 enable drops", conv_en, 1'b0);
        @(negedge clk);
        conv_busy = 1'b0; conv_done = 1'b1; conv_result = 16'h0050; @(negedge clk);
        conv_done = 1'b0;
        chk("R11 result absorbed", temp_value, 16'h0050);
        chk("R11 flags updated", temp_status, 8'h0B);
        chk("R11 stays stopped", conv_en, 1'b0);
        dis = 1'b0; @(negedge clk);
        chk("R13 resume", conv_en, 1'b1);

        repeat (3) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule